// File: doc/BRIEF.md
# PC Card Memory Cycle Timer

This block sequences the control strobes of a single word-wide memory read or write on a PC Card socket. A cycle always passes through three phases in a fixed order: a setup phase in which the card enables, the attribute/common space select, the address and (for writes) the write data are presented; a command phase in which the output-enable or write-enable strobe is driven low; and a recovery phase in which address and write data are held after the command has been released.

Each phase length in clocks is a prescale multiplier times one more than an 8-bit programmed count. Two independent timer sets hold the three counts and a prescale code each. A set is chosen when the cycle starts and cannot change until it ends. The card may stretch the command phase by pulling its active-low wait line during an early part of that phase. The timing values are loaded through a simple write port; how that port is reached from the host is outside the block.

Top module: `pccard_mem_timer`

## Requirements
- R1: Out of reset, and whenever a cycle is not running, oe_n, we_n, reg_n and both ce_n bits are high, and busy, done, addr_vld, wdata_oe and rdata_cap are low. Reset also aborts a running cycle and reloads both timer sets with setup 1, command 6, recovery 3 and prescale code 0.
- R2: A start sampled high while idle begins a cycle on the next clock. The setup phase lasts P*(S+1) clocks with both strobes high, then the command phase lasts P*(C+1) clocks, then recovery lasts P*(R+1) clocks, where S, C, R are the selected set's counts. With reset values and P=1 this gives 2, 7 and 4 clocks.
- R3: The 2-bit prescale code selects P: code 0 gives 1, code 1 gives 2, code 2 gives 4, code 3 gives 16.
- R4: The timing write port uses a 3-bit address whose bit 2 selects the set and whose low two bits select the field: 0 setup count, 1 command count, 2 recovery count, 3 prescale code (data bits 1:0). The set select input tset is sampled with start; later changes of tset do not affect the running cycle.
- R5: A read (is_write low) drives oe_n low and keeps we_n high through the command phase; a write drives we_n low and keeps oe_n high. wdata_oe is high for every clock of a write cycle and never during a read.
- R6: Throughout a cycle both ce_n bits are low, addr_vld is high, and reg_n is low exactly when attr_sel was high at start.
- R7: If wait_n is sampled low while at least two command clocks remain (within the first C_len-2 clocks of the command phase, C_len = P*(C+1)), the command strobe stays low until wait_n is sampled high; it then stays low for exactly one further clock and recovery follows. A wait first seen in clock k of the command and held for n clocks gives a command phase of k+n+1 clocks.
- R8: A low wait_n first seen only in the last two command clocks has no effect on the command length.
- R9: A start request while a cycle is running is ignored: phase lengths are unchanged and the block is idle after the cycle ends.
- R10: done is high for exactly one clock, the last clock of recovery, after which the block is idle. For reads rdata_cap is high for exactly one clock, the last clock with oe_n low; for writes it never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_addr | input | 3 | Timing register select: set in bit 2, field in bits 1:0 |
| cfg_data | input | 8 | Timing register write data |
| start | input | 1 | Cycle request, sampled while idle |
| is_write | input | 1 | 1 = write cycle, 0 = read cycle |
| attr_sel | input | 1 | 1 = attribute space (reg_n asserted) |
| tset | input | 1 | Timer set select, sampled with start |
| wait_n | input | 1 | Card wait, active low, already synchronised |
| ce_n | output | 2 | Card enables, active low |
| reg_n | output | 1 | Attribute space select, active low |
| oe_n | output | 1 | Output enable strobe, active low |
| we_n | output | 1 | Write enable strobe, active low |
| addr_vld | output | 1 | Address bus drive enable |
| wdata_oe | output | 1 | Write data drive enable |
| rdata_cap | output | 1 | Read data capture pulse |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The checker watches, on every clock, that the two command strobes are never low together, that a command strobe is only low under asserted card enables and address, that a cycle opens with both strobes high, that done is a single pulse followed by idle, that the capture pulse coincides with the last low clock of output enable, and that an idle block holds every strobe inactive. Exact phase lengths for each prescale code and timer set, the latching of the set select, the wait stretch arithmetic and the boundary where wait stops being honoured, the ignoring of a start during a cycle, and the restoring of reset values can only be shown by the bench's scenarios, which count clocks per phase against values computed from the requirements.

// File: rtl/pcmt_pkg.sv
// Shared types and helpers for the PC Card memory cycle timer.
// Assumes the prescale code is always two bits wide.
package pcmt_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_CMD   = 2'd2,
        PH_REC   = 2'd3
    } phase_e;

    // Maps a prescale code to a left-shift amount (x1, x2, x4, x16).
    function automatic logic [2:0] ps_shift(input logic [1:0] code);
        logic [2:0] sh;
        case (code)
            2'd0:    sh = 3'd0;
            2'd1:    sh = 3'd1;
            2'd2:    sh = 3'd2;
            default: sh = 3'd4;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/pcmt_regbank.sv
// Timing register bank: NSETS timer sets, each holding setup, command and
// recovery counts plus a 2-bit prescale code. Written through a plain
// address/data port; the selected set is read combinationally.
// Assumes the writer never targets a set index at or beyond NSETS.
module pcmt_regbank #(
    parameter int CNT_W  = 8,
    parameter int NSETS  = 2,
    parameter int SEL_W  = 1,
    parameter int ADDR_W = SEL_W + 2,
    parameter logic [CNT_W-1:0] RST_SU = 1,
    parameter logic [CNT_W-1:0] RST_CM = 6,
    parameter logic [CNT_W-1:0] RST_RC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [CNT_W-1:0]  su_cnt,
    output logic [CNT_W-1:0]  cm_cnt,
    output logic [CNT_W-1:0]  rc_cnt,
    output logic [1:0]        ps_code
);

    logic [CNT_W-1:0] su_q [NSETS];
    logic [CNT_W-1:0] cm_q [NSETS];
    logic [CNT_W-1:0] rc_q [NSETS];
    logic [1:0]       ps_q [NSETS];

    logic [SEL_W-1:0] wr_set;
    logic [1:0]       wr_fld;

    assign wr_set = cfg_addr[ADDR_W-1:2];
    assign wr_fld = cfg_addr[1:0];

    // Register storage: reset to defaults, update the addressed field.
    always_ff @(posedge clk) begin
        for (int s = 0; s < NSETS; s++) begin
            if (!rst_n) begin
                su_q[s] <= RST_SU;
                cm_q[s] <= RST_CM;
                rc_q[s] <= RST_RC;
                ps_q[s] <= 2'd0;
            end else if (cfg_we && (wr_set == SEL_W'(s))) begin
                case (wr_fld)
                    2'd0:    su_q[s] <= cfg_data;
                    2'd1:    cm_q[s] <= cfg_data;
                    2'd2:    rc_q[s] <= cfg_data;
                    default: ps_q[s] <= cfg_data[1:0];
                endcase
            end
        end
    end

    // Read mux for the set the sequencer is using.
    always_comb begin
        su_cnt  = su_q[rd_sel];
        cm_cnt  = cm_q[rd_sel];
        rc_cnt  = rc_q[rd_sel];
        ps_code = ps_q[rd_sel];
    end

endmodule

// File: rtl/pcmt_sequencer.sv
// Phase sequencer: walks idle -> setup -> command -> recovery -> idle with
// one down counter loaded with P*(N+1)-1 per phase, and stretches the
// command phase on card wait. Assumes wait_n is already synchronous.
module pcmt_sequencer
    import pcmt_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 1,
    parameter int TW    = CNT_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_write,
    input  logic             attr_sel,
    input  logic [SEL_W-1:0] tset,
    input  logic             wait_n,
    input  logic [CNT_W-1:0] su_cnt,
    input  logic [CNT_W-1:0] cm_cnt,
    input  logic [CNT_W-1:0] rc_cnt,
    input  logic [1:0]       ps_code,
    output logic [SEL_W-1:0] rd_sel,
    output phase_e           phase,
    output logic             wr_q,
    output logic             attr_q,
    output logic             cmd_last,
    output logic             rec_last
);

    logic [TW-1:0]    cnt;
    logic             hold;
    logic [SEL_W-1:0] sel_q;

    // Phase length minus one, in clocks, for a count and prescale code.
    function automatic logic [TW-1:0] len_m1(input logic [CNT_W-1:0] n,
                                             input logic [1:0] code);
        return ((TW'(n) + TW'(1)) << ps_shift(code)) - TW'(1);
    endfunction

    // While idle the incoming select addresses the bank; later the latched one.
    assign rd_sel   = (phase == PH_IDLE) ? tset : sel_q;
    assign cmd_last = (phase == PH_CMD) && (cnt == '0);
    assign rec_last = (phase == PH_REC) && (cnt == '0);

    // Phase state, counter, wait hold and per-cycle latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            hold   <= 1'b0;
            wr_q   <= 1'b0;
            attr_q <= 1'b0;
            sel_q  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase  <= PH_SETUP;
                        cnt    <= len_m1(su_cnt, ps_code);
                        wr_q   <= is_write;
                        attr_q <= attr_sel;
                        sel_q  <= tset;
                        hold   <= 1'b0;
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_CMD;
                        cnt   <= len_m1(cm_cnt, ps_code);
                    end else begin
                        cnt <= cnt - TW'(1);
                    end
                end
                PH_CMD: begin
                    if (hold) begin
                        if (wait_n) begin
                            hold <= 1'b0;
                            cnt  <= '0;
                        end
                    end else if (!wait_n && (cnt >= TW'(2))) begin
                        hold <= 1'b1;
                    end else if (cnt == '0) begin
                        phase <= PH_REC;
                        cnt   <= len_m1(rc_cnt, ps_code);
                    end else begin
                        cnt <= cnt - TW'(1);
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - TW'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/pcmt_strobes.sv
// Strobe decode: turns the registered phase and per-cycle latches into the
// socket control levels. Purely combinational; assumes registered inputs.
module pcmt_strobes
    import pcmt_pkg::*;
#(
    parameter int CE_W = 2
) (
    input  phase_e          phase,
    input  logic            wr_q,
    input  logic            attr_q,
    input  logic            cmd_last,
    input  logic            rec_last,
    output logic [CE_W-1:0] ce_n,
    output logic            reg_n,
    output logic            oe_n,
    output logic            we_n,
    output logic            addr_vld,
    output logic            wdata_oe,
    output logic            rdata_cap,
    output logic            busy,
    output logic            done
);

    logic active;
    logic in_cmd;

    // Level decode of every socket-side control from the phase.
    always_comb begin
        active    = (phase != PH_IDLE);
        in_cmd    = (phase == PH_CMD);
        ce_n      = active ? '0 : '1;
        reg_n     = !(active && attr_q);
        oe_n      = !(in_cmd && !wr_q);
        we_n      = !(in_cmd && wr_q);
        addr_vld  = active;
        wdata_oe  = active && wr_q;
        rdata_cap = cmd_last && !wr_q;
        busy      = active;
        done      = rec_last;
    end

endmodule

// File: rtl/pccard_mem_timer.sv
// PC Card memory cycle timer, top level. Joins the timing register bank,
// the phase sequencer and the strobe decode. Assumes wait_n has been
// synchronised to clk and that the host holds cfg writes off mid-cycle.
module pccard_mem_timer
    import pcmt_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int NSETS  = 2,
    parameter int CE_W   = 2,
    localparam int SEL_W  = (NSETS > 1) ? $clog2(NSETS) : 1,
    localparam int ADDR_W = SEL_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_data,
    input  logic              start,
    input  logic              is_write,
    input  logic              attr_sel,
    input  logic [SEL_W-1:0]  tset,
    input  logic              wait_n,
    output logic [CE_W-1:0]   ce_n,
    output logic              reg_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              addr_vld,
    output logic              wdata_oe,
    output logic              rdata_cap,
    output logic              busy,
    output logic              done
);

    logic [SEL_W-1:0] rd_sel;
    logic [CNT_W-1:0] su_cnt, cm_cnt, rc_cnt;
    logic [1:0]       ps_code;
    phase_e           phase;
    logic             wr_q, attr_q, cmd_last, rec_last;

    pcmt_regbank #(
        .CNT_W (CNT_W),
        .NSETS (NSETS),
        .SEL_W (SEL_W),
        .ADDR_W(ADDR_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_addr(cfg_addr),
        .cfg_data(cfg_data),
        .rd_sel  (rd_sel),
        .su_cnt  (su_cnt),
        .cm_cnt  (cm_cnt),
        .rc_cnt  (rc_cnt),
        .ps_code (ps_code)
    );

    pcmt_sequencer #(
        .CNT_W(CNT_W),
        .SEL_W(SEL_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .is_write(is_write),
        .attr_sel(attr_sel),
        .tset    (tset),
        .wait_n  (wait_n),
        .su_cnt  (su_cnt),
        .cm_cnt  (cm_cnt),
        .rc_cnt  (rc_cnt),
        .ps_code (ps_code),
        .rd_sel  (rd_sel),
        .phase   (phase),
        .wr_q    (wr_q),
        .attr_q  (attr_q),
        .cmd_last(cmd_last),
        .rec_last(rec_last)
    );

    pcmt_strobes #(
        .CE_W(CE_W)
    ) u_strb (
        .phase    (phase),
        .wr_q     (wr_q),
        .attr_q   (attr_q),
        .cmd_last (cmd_last),
        .rec_last (rec_last),
        .ce_n     (ce_n),
        .reg_n    (reg_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .addr_vld (addr_vld),
        .wdata_oe (wdata_oe),
        .rdata_cap(rdata_cap),
        .busy     (busy),
        .done     (done)
    );

endmodule

// File: rtl/pcmt_checker.sv
// Property checker for the PC Card memory cycle timer, bound to the top.
// Observes only top-level ports.
module pcmt_checker #(
    parameter int CE_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [CE_W-1:0] ce_n,
    input logic            oe_n,
    input logic            we_n,
    input logic            addr_vld,
    input logic            wdata_oe,
    input logic            rdata_cap,
    input logic            busy,
    input logic            done
);

    p_one_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    p_wdrive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> wdata_oe);

    p_cmd_under_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n) |-> (ce_n == '0 && addr_vld));

    p_setup_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (oe_n && we_n));

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    p_cap_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_cap |-> (!oe_n ##1 oe_n));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (oe_n && we_n && ce_n == '1 && !wdata_oe));

    p_no_early_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

bind pccard_mem_timer pcmt_checker #(.CE_W(CE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .addr_vld (addr_vld),
    .wdata_oe (wdata_oe),
    .rdata_cap(rdata_cap),
    .busy     (busy),
    .done     (done)
);

// File: tb/pccard_mem_timer_test.sv
`timescale 1ns/1ps
module pccard_mem_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_data = '0;
    logic       start = 1'b0;
    logic       is_write = 1'b0;
    logic       attr_sel = 1'b0;
    logic [0:0] tset = '0;
    logic       wait_n = 1'b1;
    logic [1:0] ce_n;
    logic       reg_n, oe_n, we_n, addr_vld, wdata_oe, rdata_cap, busy, done;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pccard_mem_timer uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .start(start), .is_write(is_write),
        .attr_sel(attr_sel), .tset(tset), .wait_n(wait_n), .ce_n(ce_n),
        .reg_n(reg_n), .oe_n(oe_n), .we_n(we_n), .addr_vld(addr_vld),
        .wdata_oe(wdata_oe), .rdata_cap(rdata_cap), .busy(busy), .done(done)
    );

    // ps0: set-0 prescale code, wf/wl: wait start clock and length in
    // command (0 = none), rs: command clock at which start is re-pulsed.
    typedef struct packed {
        int ps0; int wr; int attr; int ts; int wf; int wl; int rs;
        int es; int ec; int er;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{0, 0, 0, 0, 0, 0,  0,  2,   7,  4},
        '{0, 1, 1, 0, 0, 0,  0,  2,   7,  4},
        '{0, 0, 1, 1, 0, 0,  0,  6,  10,  2},
        '{0, 1, 0, 1, 0, 0,  0,  6,  10,  2},
        '{2, 0, 0, 0, 0, 0,  0,  8,  28, 16},
        '{3, 1, 0, 0, 0, 0,  0, 32, 112, 64},
        '{1, 0, 1, 0, 0, 0,  0,  4,  14,  8},
        '{0, 0, 0, 0, 1, 10, 0,  2,  12,  4},
        '{0, 1, 0, 0, 5, 3,  0,  2,   9,  4},
        '{0, 0, 0, 0, 6, 3,  0,  2,   7,  4},
        '{0, 1, 1, 1, 1, 4,  0,  6,   6,  2},
        '{0, 0, 0, 0, 0, 0,  3,  2,   7,  4}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle_check(input string tag);
        chk(oe_n && we_n && reg_n && ce_n == 2'b11 && !busy && !done &&
            !addr_vld && !wdata_oe && !rdata_cap, tag,
            {oe_n, we_n, reg_n, ce_n, busy, done, addr_vld, wdata_oe, rdata_cap},
            9'b111110000);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int s = 0, c = 0, r = 0, dn = 0, cp = 0, done_at = -1, cap_at = -1;
        int bad = 0, n = 0;
        bit seen_cmd = 0;
        cfg_write(3'b011, 8'(v.ps0));
        @(negedge clk);
        is_write = v.wr[0]; attr_sel = v.attr[0]; tset = v.ts[0:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        tset = ~tset; // R4: must not affect the running cycle
        while (busy && n < 6000) begin
            if (!oe_n || !we_n) begin
                c++; seen_cmd = 1;
                if (v.wr != 0 ? !oe_n : !we_n) bad++;
                if (rdata_cap) cap_at = c;
                wait_n = !(v.wf != 0 && c >= v.wf && c < v.wf + v.wl);
                start = (v.rs != 0 && c == v.rs);
            end else begin
                wait_n = 1'b1;
                start = 1'b0;
                if (!seen_cmd) s++; else r++;
            end
            if (done) begin dn++; done_at = r; end
            if (rdata_cap) cp++;
            if (ce_n != 2'b00 || !addr_vld || reg_n != (v.attr == 0) ||
                wdata_oe != (v.wr != 0)) bad++;
            @(negedge clk);
            n++;
        end
        wait_n = 1'b1; start = 1'b0;
        $display("vector %0d: setup %0d cmd %0d rec %0d", idx, s, c, r);
        chk(s == v.es, "R2/R3/R4 setup length", s, v.es);
        chk(c == v.ec, "R2/R3/R7/R8 command length", c, v.ec);
        chk(r == v.er, "R2/R3 recovery length", r, v.er);
        chk(bad == 0, "R5/R6 strobe and enable levels", bad, 0);
        chk(dn == 1 && done_at == v.er, "R10 done pulse", done_at, v.er);
        if (v.wr != 0) chk(cp == 0, "R10 no capture on write", cp, 0);
        else chk(cp == 1 && cap_at == v.ec, "R10 capture on last OE clock", cap_at, v.ec);
        idle_check("R10 idle after cycle (R9 no restart)");
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        idle_check("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("R1 idle after reset release");

        // R4: set 1 = setup 2, command 4, recovery 0, prescale x2
        cfg_write(3'b100, 8'd2);
        cfg_write(3'b101, 8'd4);
        cfg_write(3'b110, 8'd0);
        cfg_write(3'b111, 8'd1);

        for (int i = 0; i < NV; i++) run_vec(VT[i], i);

        // R1: reset in the middle of a command aborts the cycle
        @(negedge clk);
        is_write = 1'b0; tset = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(!oe_n, "R1 precondition command active", oe_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        idle_check("R1 reset aborts cycle");
        rst_n = 1'b1;
        // R1: set 1 back at default values (2,7,4 clocks)
        run_vec('{0, 0, 0, 1, 0, 0, 0, 2, 7, 4}, 99);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule